// File: doc/BRIEF.md
# Local-Bus Interrupt Aggregator

This block gathers up to sixteen level-sensitive interrupt request lines from local-bus devices into one interrupt output toward the processor. Each request line is sampled every clock into a source register, which simply follows the line. A software-writable enable mask selects the sources that are allowed to contribute. The combined output is high whenever at least one source is both requesting and enabled.

Software reaches the block through a small register port with byte, halfword and word accesses. One register holds the enable mask and can be read and written. The other register is read-only. Instead of returning the raw source bitmap, it returns a vector code that identifies the lowest-numbered source that is requesting and enabled. Reading that code has no side effects, so an interrupt stays pending until its device drops the line.

Top module: `lbus_irq_agg`

## Requirements
- R1: After reset the enable mask reads 0x0010, no source is pending, the vector reads 0 and `irqOut` is low. A request on line 4 alone is therefore enough to raise the output.
- R2: Each source bit copies its input line at every clock edge. A line that is high is seen as pending after the next edge, and a line that drops is no longer pending after the next edge.
- R3: `irqOut` is high exactly when (source AND mask) is non-zero. It shows the effect of an input change or a mask write one clock edge after that change, and not before.
- R4: A halfword read at offset 0 returns ((n + 1) << 2), where n is the lowest-numbered source that is both pending and enabled. It returns 0 when no source is pending and enabled. Writes to offset 0 have no effect.
- R5: The enable mask is read and written as a halfword at offset 2, using bits [15:0] of the data. For halfword accesses, address bit 0 is ignored.
- R6: A byte access (size code 2'b00) uses data bits [7:0]. A byte write at offset 2 replaces mask bits [7:0] and a byte write at offset 3 replaces mask bits [15:8]; the other byte keeps its value. A byte read returns the addressed byte of the aligned halfword.
- R7: A word access (size code 2'b10) is handled as two halfwords: data bits [15:0] go to the aligned offset and bits [31:16] go to that offset plus 2. A word read at offset 0 returns {mask, vector}, and a word write at offset 0 loads the mask from bits [31:16].
- R8: Writes to any halfword other than offset 2 leave the mask unchanged. Reads of such halfwords return 0.
- R9: Reading the vector never clears a source and never changes `irqOut`. Repeated reads return the same code while the inputs and the mask are unchanged.
- R10: Size code 2'b11 is no access at all: `busRdata` is 0 and a write with this code does not change the mask. The halfword size code is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | NUM_SRC | Level-sensitive request lines, synchronous to clk |
| busWe | input | 1 | Write strobe for the current access |
| busSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 none |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data, right-aligned |
| busRdata | output | 32 | Read data, combinational, right-aligned |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The case that needs care is a mask write that falls in the same clock cycle as a change on the request lines. The registered output must then reflect both the new mask and the new sources after that one edge, and not a mix of old and new. The vector table drives a new line pattern and a halfword mask write at the same negative edge. It checks that `irqOut` still holds the previous result before the edge. After the edge it compares the output, the vector read and the mask read with values worked out by hand. A second overlap is a vector read made in the same cycle as a mask write: the read must show the state from before the write.

// File: rtl/lbus_irq_pkg.sv
package lbus_irq_pkg;

  localparam int unsigned REG_W = 16;
  localparam int unsigned LANES = REG_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } accSize_e;

  // Strobes from the access decoder to the datapath.
  typedef struct packed {
    logic [LANES-1:0] maskByteWe;
    logic [REG_W-1:0] maskWrData;
  } maskStrobe_t;

endpackage

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl
  import lbus_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busWe,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [REG_W-1:0]  vecCode,
  input  logic [REG_W-1:0]  maskQ,
  output maskStrobe_t       strb,
  output logic [31:0]       busRdata
);

  localparam logic [ADDR_W-1:0] OFF_VEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] loAddr;
  logic [ADDR_W-1:0] hiAddr;
  logic [REG_W-1:0]  loHalf;
  logic [REG_W-1:0]  hiHalf;

  assign loAddr = {busAddr[ADDR_W-1:1], 1'b0};
  assign hiAddr = loAddr + HALF_STEP;

  function automatic logic [REG_W-1:0] halfRead(
    input logic [ADDR_W-1:0] a,
    input logic [REG_W-1:0]  vec,
    input logic [REG_W-1:0]  msk
  );
    if (a == OFF_VEC)       return vec;
    else if (a == OFF_MASK) return msk;
    else                    return '0;
  endfunction

  assign loHalf = halfRead(loAddr, vecCode, maskQ);
  assign hiHalf = halfRead(hiAddr, vecCode, maskQ);

  // Read path: right-aligned result per access size.
  always_comb begin
    unique case (accSize_e'(busSize))
      SZ_BYTE: busRdata = {24'h0, busAddr[0] ? loHalf[15:8] : loHalf[7:0]};
      SZ_HALF: busRdata = {16'h0, loHalf};
      SZ_WORD: busRdata = {hiHalf, loHalf};
      default: busRdata = 32'h0;
    endcase
  end

  // Write path: only the mask halfword accepts data.
  always_comb begin
    strb.maskByteWe = '0;
    strb.maskWrData = maskQ;
    if (busWe) begin
      unique case (accSize_e'(busSize))
        SZ_BYTE: begin
          if (loAddr == OFF_MASK) begin
            if (busAddr[0]) begin
              strb.maskByteWe[1]    = 1'b1;
              strb.maskWrData[15:8] = busWdata[7:0];
            end else begin
              strb.maskByteWe[0]    = 1'b1;
              strb.maskWrData[7:0]  = busWdata[7:0];
            end
          end
        end
        SZ_HALF: begin
          if (loAddr == OFF_MASK) begin
            strb.maskByteWe = '1;
            strb.maskWrData = busWdata[15:0];
          end
        end
        SZ_WORD: begin
          if (loAddr == OFF_MASK) begin
            strb.maskByteWe = '1;
            strb.maskWrData = busWdata[15:0];
          end else if (hiAddr == OFF_MASK) begin
            strb.maskByteWe = '1;
            strb.maskWrData = busWdata[31:16];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lbus_irq_dp.sv
module lbus_irq_dp
  import lbus_irq_pkg::*;
#(
  parameter int               NUM_SRC    = 16,
  parameter logic [REG_W-1:0] MASK_RESET = 16'h0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  maskStrobe_t        strb,
  output logic [REG_W-1:0]   maskQ,
  output logic [REG_W-1:0]   vecCode,
  output logic               irqOut
);

  logic [REG_W-1:0]   maskNext;
  logic [NUM_SRC-1:0] srcQ;
  logic [NUM_SRC-1:0] pending;
  logic               irqQ;

  // Byte-lane merge of the mask.
  for (genvar b = 0; b < LANES; b++) begin : gLane
    assign maskNext[b*8 +: 8] = strb.maskByteWe[b] ? strb.maskWrData[b*8 +: 8]
                                                   : maskQ[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ <= MASK_RESET;
      srcQ  <= '0;
      irqQ  <= 1'b0;
    end else begin
      maskQ <= maskNext;
      srcQ  <= irqIn;
      irqQ  <= |(irqIn & maskNext[NUM_SRC-1:0]);
    end
  end

  assign pending = srcQ & maskQ[NUM_SRC-1:0];
  assign irqOut  = irqQ;

  // Lowest pending index wins; code is (index + 1) * 4.
  always_comb begin
    vecCode = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) vecCode = REG_W'((i + 1) << 2);
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irqOut == (|(srcQ & maskQ[NUM_SRC-1:0]))); // R3

  AST_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (vecCode == '0) == (pending == '0)); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strb.maskByteWe == '0) |=> $stable(maskQ)); // R8

endmodule

// File: rtl/lbus_irq_agg.sv
module lbus_irq_agg
  import lbus_irq_pkg::*;
#(
  parameter int               NUM_SRC    = 16,
  parameter int               ADDR_W     = 12,
  parameter logic [REG_W-1:0] MASK_RESET = 16'h0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busWe,
  input  logic [1:0]         busSize,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqOut
);

  maskStrobe_t      strb;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] vecCode;

  lbus_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWe    (busWe),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .vecCode  (vecCode),
    .maskQ    (maskQ),
    .strb     (strb),
    .busRdata (busRdata)
  );

  lbus_irq_dp #(.NUM_SRC(NUM_SRC), .MASK_RESET(MASK_RESET)) uDp (
    .clk     (clk),
    .rst     (rst),
    .irqIn   (irqIn),
    .strb    (strb),
    .maskQ   (maskQ),
    .vecCode (vecCode),
    .irqOut  (irqOut)
  );

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busWe |-> (strb.maskByteWe == '0)); // R9

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busSize == 2'b11) |-> (busRdata == 32'h0 && strb.maskByteWe == '0)); // R10

endmodule

// File: tb/lbus_irq_agg_test.sv
module lbus_irq_agg_test;

  localparam int NSTEP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irqIn = '0;
  logic        busWe = 1'b0;
  logic [1:0]  busSize = 2'b01;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lbus_irq_agg uut (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busWe(busWe), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // {lines, mask, expected vector, expected irqOut}
  localparam logic [48:0] STEPS [NSTEP] = '{
    {16'h0001, 16'h0001, 16'h0004, 1'b1},
    {16'h0001, 16'h0000, 16'h0000, 1'b0},
    {16'h8000, 16'hFFFF, 16'h0040, 1'b1},
    {16'h00F0, 16'h00C0, 16'h001C, 1'b1},
    {16'h0A00, 16'h0F00, 16'h0028, 1'b1},
    {16'hFFFF, 16'h8000, 16'h0040, 1'b1},
    {16'h1234, 16'h0000, 16'h0000, 1'b0},
    {16'h0018, 16'h0010, 16'h0014, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busSize = sz; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [11:0] a, output logic [31:0] d);
    busWe = 1'b0; busSize = sz; busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic        prevIrq;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", {31'h0, irqOut}, 32'h0);
    rd(2'b01, 12'h000, r); chk("R1 vector", r, 32'h0);
    rd(2'b01, 12'h002, r); chk("R1 mask", r, 32'h0010);
    @(negedge clk); irqIn = 16'h0010;
    @(negedge clk);
    chk("R1 line4 enabled", {31'h0, irqOut}, 32'h1);
    rd(2'b01, 12'h000, r); chk("R1 line4 vector", r, 32'h0014);

    // R2 line drop
    @(negedge clk); irqIn = 16'h0000;
    @(negedge clk);
    chk("R2 drop irq", {31'h0, irqOut}, 32'h0);
    rd(2'b01, 12'h000, r); chk("R2 drop vector", r, 32'h0);

    // Table: line change and mask write in the same cycle
    prevIrq = irqOut;
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      irqIn = STEPS[s][48:33];
      busWe = 1'b1; busSize = 2'b01; busAddr = 12'h002;
      busWdata = {16'h0, STEPS[s][32:17]};
      #1;
      chk("R3 latency", {31'h0, irqOut}, {31'h0, prevIrq});
      @(negedge clk);
      busWe = 1'b0;
      chk("R3 irqOut", {31'h0, irqOut}, {31'h0, STEPS[s][0]});
      rd(2'b01, 12'h000, r); chk("R4 vector", r, {16'h0, STEPS[s][16:1]});
      rd(2'b01, 12'h002, r); chk("R5 mask", r, {16'h0, STEPS[s][32:17]});
      prevIrq = STEPS[s][0];
    end

    // R4 vector read in the cycle of a mask write sees old state
    @(negedge clk);
    busWe = 1'b1; busSize = 2'b01; busAddr = 12'h002; busWdata = 32'h0008;
    #1;
    wr_rd_same: begin
      busAddr = 12'h000;
      busWe = 1'b0;
      #1;
      chk("R4 old vector", busRdata, 32'h0014);
      busWe = 1'b1; busAddr = 12'h002;
    end
    @(negedge clk);
    busWe = 1'b0;
    rd(2'b01, 12'h000, r); chk("R4 new vector", r, 32'h0010);

    // R5 odd halfword address aligns down
    rd(2'b01, 12'h003, r); chk("R5 odd half", r, 32'h0008);

    // R6 byte merges
    wr(2'b01, 12'h002, 32'h1234);
    wr(2'b00, 12'h002, 32'h00AB);
    rd(2'b01, 12'h002, r); chk("R6 low byte", r, 32'h12AB);
    wr(2'b00, 12'h003, 32'h00CD);
    rd(2'b01, 12'h002, r); chk("R6 high byte", r, 32'hCDAB);
    rd(2'b00, 12'h002, r); chk("R6 read byte2", r, 32'h00AB);
    rd(2'b00, 12'h003, r); chk("R6 read byte3", r, 32'h00CD);

    // R7 word accesses
    wr(2'b10, 12'h000, 32'h5A5A_FFFF);
    rd(2'b01, 12'h002, r); chk("R7 word wr at 0", r, 32'h5A5A);
    wr(2'b10, 12'h002, 32'hFFFF_00F0);
    rd(2'b01, 12'h002, r); chk("R7 word wr at 2", r, 32'h00F0);
    @(negedge clk); irqIn = 16'h0020;
    @(negedge clk);
    rd(2'b10, 12'h000, r); chk("R7 word rd at 0", r, 32'h00F0_0018);
    rd(2'b10, 12'h002, r); chk("R7 word rd at 2", r, 32'h0000_00F0);

    // R8 ignored writes, empty reads
    wr(2'b01, 12'h000, 32'hFFFF);
    rd(2'b01, 12'h002, r); chk("R8 write at 0", r, 32'h00F0);
    rd(2'b01, 12'h000, r); chk("R8 vector kept", r, 32'h0018);
    wr(2'b01, 12'h006, 32'hFFFF);
    rd(2'b01, 12'h002, r); chk("R8 write at 6", r, 32'h00F0);
    wr(2'b00, 12'h001, 32'h00FF);
    rd(2'b01, 12'h002, r); chk("R8 byte at 1", r, 32'h00F0);
    rd(2'b01, 12'h004, r); chk("R8 read at 4", r, 32'h0);

    // R9 reads have no side effects
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rd(2'b01, 12'h000, r); chk("R9 repeat vector", r, 32'h0018);
      chk("R9 irq held", {31'h0, irqOut}, 32'h1);
    end

    // R10 size code 11
    wr(2'b11, 12'h002, 32'h0000);
    rd(2'b01, 12'h002, r); chk("R10 no write", r, 32'h00F0);
    rd(2'b11, 12'h002, r); chk("R10 read zero", r, 32'h0);
    chk("R10 irq kept", {31'h0, irqOut}, 32'h1);

    finish_run();
  end

endmodule